// File: doc/BRIEF.md
# Owner Destination Predictor

This block sits beside a node's cache controller in a shared-memory multiprocessor. It guesses where a coherence request should go. It keeps a small tagged table. Each entry covers one address granule, which is a cache block or a larger aligned region, and remembers one processor that most likely owns the data. When the owner is known, the request goes to that node as well as to the home directory and the requester itself. The owner can then answer directly instead of through a forwarded, three-hop transaction, and traffic stays close to what a directory protocol sends.

The lookup port takes a request address and, one cycle later, returns a destination mask with one bit per node. The training port takes four kinds of event: data arriving from a peer, a peer write request, a peer read request, and a response from memory. Each event comes with the node involved. The table has one level and is direct-mapped on the granule number. A training event whose tag differs from the stored one takes over the entry.

Top module: `owner_dest_pred`

## Requirements
- R1: After reset every table entry is empty, `pred_valid` is low and `pred_mask` is zero. Any lookup made before training returns `pred_hit` = 0.
- R2: A lookup with `lk_valid` high at a clock edge gives `pred_valid` high after that edge, for exactly one cycle per lookup. Bit i of `pred_mask` stands for node i. Bit SELF_ID is always set, and so is the bit of the home node, which is (lk_addr >> GRAIN_W) mod N_NODES.
- R3: A lookup whose entry is empty or holds a different tag returns `pred_hit` = 0 and a mask holding only the home and self bits.
- R4: A training event of kind 0 (data from a peer) makes `tr_node` the owner of the addressed granule. Later lookups of that granule add the `tr_node` bit to the mask.
- R5: A training event of kind 1 (peer write request) makes `tr_node` the owner, in the same way as R4.
- R6: A training event of kind 3 (memory response) clears the owner. Later lookups hit (`pred_hit` = 1) and return only the home and self bits.
- R7: A training event of kind 2 (peer read request) leaves a known owner unchanged. On a tag miss it allocates the entry with no owner.
- R8: A training event whose tag misses replaces the entry at its index. The address that was tracked there before then looks up as a miss.
- R9: When the owner equals SELF_ID, the mask adds no bit for it. When the owner is the home node, the mask has just those two bits. The mask never has more than three bits set.
- R10: All addresses inside one 2^GRAIN_W-byte granule share a single entry. The granule is the index unit, and the index is the low log2(N_ENTRIES) bits of the granule number.
- R11: When a lookup and a training event reach the same entry at the same edge, the lookup returns the state from before that training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | ADDR_W | Lookup byte address |
| tr_valid | input | 1 | Training event strobe |
| tr_addr | input | ADDR_W | Training event byte address |
| tr_kind | input | 2 | 0 peer data, 1 peer write, 2 peer read, 3 memory response |
| tr_node | input | log2(N_NODES) | Node that sent the data or issued the request |
| pred_valid | output | 1 | Prediction valid, one cycle after lookup |
| pred_hit | output | 1 | Lookup found a matching tag |
| pred_mask | output | N_NODES | Predicted destination set, one bit per node |

## Verification
The hardest situations to reach from the ports are conflict eviction and ownership that overlaps with self or home. They only arise when several addresses share an index and when the trained owner happens to equal the local node or the granule's home. The bench sweeps every training kind against every node ID over granules whose home takes each value. It then runs a long pseudo-random stream over a space of only 32 granules, so four tags compete for each of eight entries. Lookups and training often hit the same entry at the same edge, and a bench-side table model predicts every result.

// File: rtl/owner_pred_pkg.sv
package owner_pred_pkg;

    typedef enum logic [1:0] {
        TRN_PEER_DATA  = 2'd0,
        TRN_PEER_WRITE = 2'd1,
        TRN_PEER_READ  = 2'd2,
        TRN_MEM_RESP   = 2'd3
    } train_kind_e;

    // Events that name a new owner
    function automatic logic names_owner(train_kind_e k);
        return (k == TRN_PEER_DATA) || (k == TRN_PEER_WRITE);
    endfunction

    // Events that keep the prior owner of a matching entry
    function automatic logic keeps_owner(train_kind_e k);
        return (k == TRN_PEER_READ);
    endfunction

endpackage

// File: rtl/odp_addr_split.sv
module odp_addr_split #(
    parameter int ADDR_W    = 16,
    parameter int GRAIN_W   = 6,
    parameter int N_NODES   = 4,
    parameter int N_ENTRIES = 8,
    localparam int NODE_W   = $clog2(N_NODES),
    localparam int IDX_W    = $clog2(N_ENTRIES),
    localparam int TAG_W    = ADDR_W - GRAIN_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag,
    output logic [NODE_W-1:0] home
);
    logic unused_offset;

    assign unused_offset = ^addr[GRAIN_W-1:0];
    assign idx  = addr[GRAIN_W +: IDX_W];
    assign tag  = addr[ADDR_W-1 : GRAIN_W+IDX_W];
    assign home = addr[GRAIN_W +: NODE_W];
endmodule

// File: rtl/odp_table.sv
module odp_table
    import owner_pred_pkg::*;
#(
    parameter int N_NODES   = 4,
    parameter int N_ENTRIES = 8,
    parameter int TAG_W     = 7,
    localparam int NODE_W   = $clog2(N_NODES),
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic              rd_own_vld,
    output logic [NODE_W-1:0] rd_own,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  train_kind_e       wr_kind,
    input  logic [NODE_W-1:0] wr_node
);
    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic              own_vld;
        logic [NODE_W-1:0] own;
    } entry_t;

    entry_t tbl [N_ENTRIES];
    entry_t rd_ent, cur_ent, nxt_ent;
    logic   wr_match;

    // Read port reflects stored state; a same-edge write lands afterwards
    always_comb begin
        rd_ent     = tbl[rd_idx];
        rd_hit     = rd_ent.vld && (rd_ent.tag == rd_tag);
        rd_own_vld = rd_hit && rd_ent.own_vld;
        rd_own     = rd_ent.own;
    end

    always_comb begin
        cur_ent  = tbl[wr_idx];
        wr_match = cur_ent.vld && (cur_ent.tag == wr_tag);
        nxt_ent.vld = 1'b1;
        nxt_ent.tag = wr_tag;
        if (names_owner(wr_kind)) begin
            nxt_ent.own_vld = 1'b1;
            nxt_ent.own     = wr_node;
        end else if (keeps_owner(wr_kind) && wr_match) begin
            nxt_ent.own_vld = cur_ent.own_vld;
            nxt_ent.own     = cur_ent.own;
        end else begin
            nxt_ent.own_vld = 1'b0;
            nxt_ent.own     = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                tbl[i] <= '0;
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= nxt_ent;
        end
    end
endmodule

// File: rtl/odp_mask_gen.sv
module odp_mask_gen #(
    parameter int N_NODES = 4,
    parameter int SELF_ID = 0,
    localparam int NODE_W = $clog2(N_NODES)
) (
    input  logic               own_vld,
    input  logic [NODE_W-1:0]  own,
    input  logic [NODE_W-1:0]  home,
    output logic [N_NODES-1:0] mask
);
    localparam logic [NODE_W-1:0] SELF_NODE = NODE_W'(SELF_ID);

    always_comb begin
        for (int n = 0; n < N_NODES; n++) begin
            mask[n] = (NODE_W'(n) == SELF_NODE) || (NODE_W'(n) == home) ||
                      (own_vld && (own != SELF_NODE) && (NODE_W'(n) == own));
        end
    end
endmodule

// File: rtl/owner_dest_pred.sv
module owner_dest_pred
    import owner_pred_pkg::*;
#(
    parameter int N_NODES   = 4,
    parameter int N_ENTRIES = 8,
    parameter int ADDR_W    = 16,
    parameter int GRAIN_W   = 6,
    parameter int SELF_ID   = 0,
    localparam int NODE_W   = $clog2(N_NODES),
    localparam int IDX_W    = $clog2(N_ENTRIES),
    localparam int TAG_W    = ADDR_W - GRAIN_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_addr,
    input  logic               tr_valid,
    input  logic [ADDR_W-1:0]  tr_addr,
    input  logic [1:0]         tr_kind,
    input  logic [NODE_W-1:0]  tr_node,
    output logic               pred_valid,
    output logic               pred_hit,
    output logic [N_NODES-1:0] pred_mask
);
    logic [IDX_W-1:0]   lk_idx, tr_idx;
    logic [TAG_W-1:0]   lk_tag, tr_tag;
    logic [NODE_W-1:0]  lk_home, tr_home_unused;
    logic               rd_hit, rd_own_vld;
    logic [NODE_W-1:0]  rd_own;
    logic [N_NODES-1:0] mask_c;

    odp_addr_split #(.ADDR_W(ADDR_W), .GRAIN_W(GRAIN_W), .N_NODES(N_NODES),
                     .N_ENTRIES(N_ENTRIES)) u_lk_split (
        .addr(lk_addr), .idx(lk_idx), .tag(lk_tag), .home(lk_home));

    odp_addr_split #(.ADDR_W(ADDR_W), .GRAIN_W(GRAIN_W), .N_NODES(N_NODES),
                     .N_ENTRIES(N_ENTRIES)) u_tr_split (
        .addr(tr_addr), .idx(tr_idx), .tag(tr_tag), .home(tr_home_unused));

    odp_table #(.N_NODES(N_NODES), .N_ENTRIES(N_ENTRIES), .TAG_W(TAG_W)) u_table (
        .clk(clk), .rst(rst),
        .rd_idx(lk_idx), .rd_tag(lk_tag),
        .rd_hit(rd_hit), .rd_own_vld(rd_own_vld), .rd_own(rd_own),
        .wr_en(tr_valid), .wr_idx(tr_idx), .wr_tag(tr_tag),
        .wr_kind(train_kind_e'(tr_kind)), .wr_node(tr_node));

    odp_mask_gen #(.N_NODES(N_NODES), .SELF_ID(SELF_ID)) u_mask (
        .own_vld(rd_own_vld), .own(rd_own), .home(lk_home), .mask(mask_c));

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_valid <= 1'b0;
            pred_hit   <= 1'b0;
            pred_mask  <= '0;
        end else begin
            pred_valid <= lk_valid;
            pred_hit   <= lk_valid && rd_hit;
            pred_mask  <= lk_valid ? mask_c : '0;
        end
    end
endmodule

// File: rtl/odp_checker.sv
module odp_checker #(
    parameter int N_NODES   = 4,
    parameter int N_ENTRIES = 8,
    parameter int ADDR_W    = 16,
    parameter int GRAIN_W   = 6,
    parameter int SELF_ID   = 0,
    localparam int NODE_W   = $clog2(N_NODES)
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic [ADDR_W-1:0]  lk_addr,
    input logic               tr_valid,
    input logic [ADDR_W-1:0]  tr_addr,
    input logic [1:0]         tr_kind,
    input logic               pred_valid,
    input logic               pred_hit,
    input logic [N_NODES-1:0] pred_mask
);
    logic unused_low;
    assign unused_low = ^{lk_addr[GRAIN_W-1:0], tr_addr[GRAIN_W-1:0], N_ENTRIES[0]};

    function automatic logic [N_NODES-1:0] min_set(logic [ADDR_W-1:0] a);
        logic [N_NODES-1:0] m;
        m = '0;
        m[SELF_ID] = 1'b1;
        m[a[GRAIN_W +: NODE_W]] = 1'b1;
        return m;
    endfunction

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> pred_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!pred_valid && pred_mask == '0));
    assert_self_home_R2: assert property (@(posedge clk) disable iff (rst)
        pred_valid |-> ((pred_mask & min_set($past(lk_addr))) == min_set($past(lk_addr))));
    assert_miss_minimal_R3: assert property (@(posedge clk) disable iff (rst)
        (pred_valid && !pred_hit) |-> (pred_mask == min_set($past(lk_addr))));
    assert_mask_size_R9: assert property (@(posedge clk) disable iff (rst)
        pred_valid |-> ($countones(pred_mask) <= 3));
    assert_memresp_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (pred_valid && $past(tr_valid, 2) && $past(tr_kind, 2) == 2'd3 &&
         !$past(tr_valid) &&
         $past(tr_addr[ADDR_W-1:GRAIN_W], 2) == $past(lk_addr[ADDR_W-1:GRAIN_W]))
        |-> (pred_hit && pred_mask == min_set($past(lk_addr))));
endmodule

bind owner_dest_pred odp_checker #(
    .N_NODES(N_NODES), .N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W),
    .GRAIN_W(GRAIN_W), .SELF_ID(SELF_ID)
) u_odp_checker (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .tr_valid(tr_valid), .tr_addr(tr_addr), .tr_kind(tr_kind),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_mask(pred_mask));

// File: tb/owner_dest_pred_bench.sv
module owner_dest_pred_bench;
    localparam int NN = 4, NE = 8, AW = 16, GW = 6, SELF = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic lk_valid = 0, tr_valid = 0;
    logic [AW-1:0] lk_addr = '0, tr_addr = '0;
    logic [1:0] tr_kind = '0, tr_node = '0;
    logic pred_valid, pred_hit;
    logic [NN-1:0] pred_mask;

    int checks = 0, fails = 0;
    bit done = 0;

    // bench-side table model
    bit m_vld [NE];
    int m_tag [NE];
    bit m_ov  [NE];
    int m_own [NE];

    always #2.5 clk = ~clk;

    owner_dest_pred #(.N_NODES(NN), .N_ENTRIES(NE), .ADDR_W(AW), .GRAIN_W(GW),
                      .SELF_ID(SELF)) u_owner_dest_pred (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .tr_valid(tr_valid), .tr_addr(tr_addr), .tr_kind(tr_kind), .tr_node(tr_node),
        .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_mask(pred_mask));

    function automatic int gran(input logic [AW-1:0] a); return int'(a) / (1 << GW); endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {valid,hit,mask} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input bit lv, input logic [AW-1:0] la, input bit tv,
                        input logic [AW-1:0] ta, input int k, input int n, input string req);
        logic [5:0] exp;
        int g, ix, hm;
        bit hit;
        g = gran(la); ix = g % NE; hm = g % NN;
        hit = m_vld[ix] && (m_tag[ix] == g / NE);
        exp = '0;
        if (lv) begin
            exp[5] = 1'b1;
            exp[4] = hit;
            exp[SELF] = 1'b1;
            exp[hm] = 1'b1;
            if (hit && m_ov[ix] && m_own[ix] != SELF) exp[m_own[ix]] = 1'b1;
        end
        lk_valid = lv; lk_addr = la; tr_valid = tv; tr_addr = ta;
        tr_kind = 2'(k); tr_node = 2'(n);
        @(posedge clk);
        @(negedge clk);
        if (tv) begin
            int tg, ti;
            bit th;
            tg = gran(ta); ti = tg % NE;
            th = m_vld[ti] && (m_tag[ti] == tg / NE);
            m_vld[ti] = 1; m_tag[ti] = tg / NE;
            if (k == 0 || k == 1) begin m_ov[ti] = 1; m_own[ti] = n; end
            else if (k == 2 && th) begin end
            else m_ov[ti] = 0;
        end
        check(req, {pred_valid, pred_hit, pred_mask}, exp);
        lk_valid = 0; tr_valid = 0;
    endtask

    task automatic train(input logic [AW-1:0] a, input int k, input int n);
        step(0, '0, 1, a, k, n, "R2");
    endtask

    task automatic look(input logic [AW-1:0] a, input string req);
        step(1, a, 0, '0, 0, 0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < NE; i++) begin m_vld[i] = 0; m_ov[i] = 0; m_tag[i] = 0; m_own[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state, then lookups miss
        check("R1", {pred_valid, pred_hit, pred_mask}, 6'b0);
        for (int a = 0; a < 4; a++) look(AW'(a * 64 + 5), "R1");
        // R4/R5/R6/R7/R9: sweep kinds x owners x homes
        for (int k = 0; k < 4; k++) begin
            for (int n = 0; n < NN; n++) begin
                for (int h = 0; h < NN; h++) begin
                    logic [AW-1:0] a;
                    a = AW'((h + 4 * ((k * 4 + n) % 16)) * 64);
                    train(a, 0, (n + 1) % NN);
                    train(a, k, n);
                    case (k)
                        0: look(a, "R4");
                        1: look(a, "R5");
                        2: look(a, "R7");
                        default: look(a, "R6");
                    endcase
                    look(a + 17, "R9");
                end
            end
        end
        // R7: peer read on a miss allocates with no owner
        train(16'h8040, 2, 3);
        look(16'h8040, "R7");
        // R8: conflict eviction
        train(16'h0100, 0, 3);
        train(16'h0100 + 16'h0200 * 4, 1, 1);
        look(16'h0100, "R8");
        look(16'h0900, "R8");
        // R10: same granule, different offsets
        train(16'h1240, 0, 1);
        for (int o = 0; o < 64; o += 21) look(AW'(16'h1240 + o), "R10");
        // R11: same-edge lookup and training on same entry
        train(16'h2080, 0, 3);
        step(1, 16'h2080, 1, 16'h2080, 3, 0, "R11");
        look(16'h2080, "R11");
        step(1, 16'h2080, 1, 16'h2080, 1, 1, "R11");
        look(16'h2080, "R11");
        // mixed pseudo-random stream over 32 granules
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] la, ta;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            la = AW'({lf[4:0], lf[15:10]});
            ta = AW'({lf[9:5], lf[5:0]});
            step(lf[11], la, lf[14], ta, int'(lf[7:6]), int'(lf[13:12]), "R2");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule